// File: doc/BRIEF.md
# Debug Port Serial Receiver with Sticky Status

This block receives asynchronous serial characters on a single input line and presents each one to a register-style host interface. The line is first passed through a two-flop synchronizer. The block watches it on a tick that runs at 16 times the bit rate. It confirms a start bit at mid-bit and then samples 8 data bits, least significant bit first. A parity bit follows if the selected mode uses one, and the frame ends with one stop bit. The finished character is then loaded into a holding register.

Three status flags go with the holding register. The ready flag shows that an unread character is waiting, and a read strobe on the holding register clears it. The overrun and parity-error flags are sticky. Once set, they stay set through any number of later characters. They clear only when the host writes the control strobe with the clear-status bit at 1. A 3-bit mode input selects even, odd, forced-low or forced-high parity, or no parity at all.

Top module: `dbg_uart_rx`

## Requirements
- R1: When the stop bit of a character has been sampled, the character appears on `rx_data_o` and `rx_ready_o` goes to 1 on the next clock edge.
- R2: A cycle with `rx_read_i` at 1, and no character completing in that cycle, clears `rx_ready_o` on the next edge.
- R3: If a character completes while `rx_ready_o` is 1 and no read happens in that cycle, `overrun_o` goes to 1 and the new character replaces the old one on `rx_data_o`.
- R4: `overrun_o` and `par_err_o` go to 0 only after a cycle with both `ctl_wr_i` and `ctl_clr_status_i` at 1. That cycle clears both flags. A read of the holding register leaves both flags unchanged.
- R5: `par_mode_i` selects the parity rule. 000 expects a parity bit that makes the count of ones among the data and parity bits even. 001 makes that count odd. 010 expects the parity bit to be 0, and 011 expects it to be 1. If the received bit differs from the expected one, `par_err_o` rises on the same edge as `rx_ready_o`.
- R6: Once `par_err_o` is 1, it stays 1 when later characters arrive with correct parity.
- R7: After the line falls, it is sampled again 8 ticks later. If the line is high at that sample, the receiver goes back to idle and sets no flag. A valid character that follows afterwards is still received correctly.
- R8: A frame is one start bit (0), then 8 data bits with the least significant bit first, then the optional parity bit, then one stop bit. After the start sample, each bit is sampled 16 ticks after the previous sample.
- R9: With `par_mode_i[2]` at 1, no parity bit is expected: the stop bit directly follows data bit 7, and `par_err_o` is never set.
- R10: A synchronous active-high `rst` sets `rx_data_o` to 0 and clears `rx_ready_o`, `overrun_o` and `par_err_o`. It also returns the receiver to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16_i | input | 1 | One-cycle pulse at 16 times the bit rate |
| ser_in_i | input | 1 | Asynchronous serial line, idle high |
| par_mode_i | input | 3 | Parity mode: 000 even, 001 odd, 010 forced 0, 011 forced 1, 1xx none |
| rx_read_i | input | 1 | Read strobe for the holding register |
| ctl_wr_i | input | 1 | Control register write strobe |
| ctl_clr_status_i | input | 1 | Clear-status bit of the control write |
| rx_data_o | output | 8 | Receive holding register |
| rx_ready_o | output | 1 | Unread character present |
| overrun_o | output | 1 | Sticky overrun flag |
| par_err_o | output | 1 | Sticky parity-error flag |

## Verification
A vector table drives characters through every parity mode. Its data values include lone ones at either end, all ones, all zeros and mixed patterns. Each mode is run once with a correct parity bit and once with an inverted one. This separates bit order, the rule for each mode, and the no-parity frame length, where a parity bit that is wrongly expected would shift in the stop bit. Directed sequences then cover the remaining cases. Two unread characters in a row test overrun and overwrite. A bad character followed by a good one shows that the error flag is sticky. A short low pulse tests glitch rejection and recovery, and a reset is applied while flags are set.

// File: rtl/dbg_rx_pkg.sv
package dbg_rx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } rx_state_e;

    // Expected parity bit for a mode whose bit 2 is 0.
    function automatic logic par_expect(input logic [1:0] kind, input logic [7:0] data);
        logic r;
        case (kind)
            2'b00:   r = ^data;      // even count of ones overall
            2'b01:   r = ~(^data);   // odd count of ones overall
            2'b10:   r = 1'b0;       // forced low
            default: r = 1'b1;       // forced high
        endcase
        return r;
    endfunction

endpackage

// File: rtl/dbg_rx_sync.sv
module dbg_rx_sync #(
    parameter int STAGES   = 2,
    parameter bit IDLE_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    typedef struct packed {
        logic [STAGES-1:0] sr;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        s_d.sr = {s_q.sr[STAGES-2:0], din};
    end

    always_ff @(posedge clk) begin
        if (rst) s_q.sr <= {STAGES{IDLE_VAL}};
        else     s_q    <= s_d;
    end

    assign dout = s_q.sr[STAGES-1];
endmodule

// File: rtl/dbg_rx_frame.sv
module dbg_rx_frame
    import dbg_rx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OS     = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              line,
    input  logic              par_en,
    output logic              done,
    output logic [DATA_W-1:0] data,
    output logic              par_bit
);
    localparam int CNT_W = $clog2(OS);
    localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(OS / 2 - 1);
    localparam logic [CNT_W-1:0] FULL_LAST = CNT_W'(OS - 1);
    localparam logic [IDX_W-1:0] IDX_LAST  = IDX_W'(DATA_W - 1);

    typedef struct packed {
        rx_state_e         st;
        logic [CNT_W-1:0]  cnt;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] sh;
        logic              pbit;
        logic              done;
    } frame_t;

    frame_t f_d, f_q;

    always_comb begin
        f_d      = f_q;
        f_d.done = 1'b0;
        if (tick) begin
            case (f_q.st)
                ST_IDLE: begin
                    if (!line) begin
                        f_d.st  = ST_START;
                        f_d.cnt = '0;
                    end
                end
                ST_START: begin
                    if (f_q.cnt == HALF_LAST) begin
                        f_d.cnt = '0;
                        f_d.idx = '0;
                        f_d.st  = line ? ST_IDLE : ST_DATA;
                    end else begin
                        f_d.cnt = f_q.cnt + 1'b1;
                    end
                end
                ST_DATA: begin
                    if (f_q.cnt == FULL_LAST) begin
                        f_d.cnt = '0;
                        f_d.sh  = {line, f_q.sh[DATA_W-1:1]};
                        if (f_q.idx == IDX_LAST) f_d.st = par_en ? ST_PAR : ST_STOP;
                        else                     f_d.idx = f_q.idx + 1'b1;
                    end else begin
                        f_d.cnt = f_q.cnt + 1'b1;
                    end
                end
                ST_PAR: begin
                    if (f_q.cnt == FULL_LAST) begin
                        f_d.cnt  = '0;
                        f_d.pbit = line;
                        f_d.st   = ST_STOP;
                    end else begin
                        f_d.cnt = f_q.cnt + 1'b1;
                    end
                end
                ST_STOP: begin
                    if (f_q.cnt == FULL_LAST) begin
                        f_d.cnt  = '0;
                        f_d.done = 1'b1;
                        f_d.st   = ST_IDLE;
                    end else begin
                        f_d.cnt = f_q.cnt + 1'b1;
                    end
                end
                default: f_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            f_q.st   <= ST_IDLE;
            f_q.cnt  <= '0;
            f_q.idx  <= '0;
            f_q.sh   <= '0;
            f_q.pbit <= 1'b0;
            f_q.done <= 1'b0;
        end else begin
            f_q <= f_d;
        end
    end

    assign done    = f_q.done;
    assign data    = f_q.sh;
    assign par_bit = f_q.pbit;
endmodule

// File: rtl/dbg_rx_status.sv
module dbg_rx_status
    import dbg_rx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              done,
    input  logic [DATA_W-1:0] data,
    input  logic              par_bit,
    input  logic [2:0]        par_mode,
    input  logic              rd,
    input  logic              clr,
    output logic [DATA_W-1:0] hold,
    output logic              ready,
    output logic              ovr,
    output logic              perr
);
    typedef struct packed {
        logic [DATA_W-1:0] hold;
        logic              ready;
        logic              ovr;
        logic              perr;
    } stat_t;

    stat_t s_d, s_q;
    logic  par_bad;

    always_comb begin
        par_bad = !par_mode[2] && (par_bit != par_expect(par_mode[1:0], data[7:0]));

        s_d = s_q;
        if (done) begin
            s_d.hold  = data;
            s_d.ready = 1'b1;
        end else if (rd) begin
            s_d.ready = 1'b0;
        end

        if (done && s_q.ready && !rd) s_d.ovr = 1'b1;
        else if (clr)                 s_d.ovr = 1'b0;

        if (done && par_bad) s_d.perr = 1'b1;
        else if (clr)        s_d.perr = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q.hold  <= '0;
            s_q.ready <= 1'b0;
            s_q.ovr   <= 1'b0;
            s_q.perr  <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign hold  = s_q.hold;
    assign ready = s_q.ready;
    assign ovr   = s_q.ovr;
    assign perr  = s_q.perr;
endmodule

// File: rtl/dbg_uart_rx.sv
module dbg_uart_rx #(
    parameter int DATA_W    = 8,
    parameter int OS        = 16,
    parameter int SYNC_STGS = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick16_i,
    input  logic              ser_in_i,
    input  logic [2:0]        par_mode_i,
    input  logic              rx_read_i,
    input  logic              ctl_wr_i,
    input  logic              ctl_clr_status_i,
    output logic [DATA_W-1:0] rx_data_o,
    output logic              rx_ready_o,
    output logic              overrun_o,
    output logic              par_err_o
);
    logic              line_s;
    logic              frm_done;
    logic [DATA_W-1:0] frm_data;
    logic              frm_pbit;
    logic              clr_stat;

    assign clr_stat = ctl_wr_i && ctl_clr_status_i;

    dbg_rx_sync #(.STAGES(SYNC_STGS), .IDLE_VAL(1'b1)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (ser_in_i),
        .dout (line_s)
    );

    dbg_rx_frame #(.DATA_W(DATA_W), .OS(OS)) u_frame (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick16_i),
        .line    (line_s),
        .par_en  (!par_mode_i[2]),
        .done    (frm_done),
        .data    (frm_data),
        .par_bit (frm_pbit)
    );

    dbg_rx_status #(.DATA_W(DATA_W)) u_status (
        .clk      (clk),
        .rst      (rst),
        .done     (frm_done),
        .data     (frm_data),
        .par_bit  (frm_pbit),
        .par_mode (par_mode_i),
        .rd       (rx_read_i),
        .clr      (clr_stat),
        .hold     (rx_data_o),
        .ready    (rx_ready_o),
        .ovr      (overrun_o),
        .perr     (par_err_o)
    );
endmodule

// File: rtl/dbg_uart_rx_chk.sv
module dbg_uart_rx_chk (
    input logic       clk,
    input logic       rst,
    input logic       done,
    input logic [2:0] par_mode_i,
    input logic       rx_read_i,
    input logic       ctl_wr_i,
    input logic       ctl_clr_status_i,
    input logic       rx_ready_o,
    input logic       overrun_o,
    input logic       par_err_o
);
    assert_ready_on_done_R1: assert property (@(posedge clk) disable iff (rst)
        done |=> rx_ready_o);

    assert_read_clears_R2: assert property (@(posedge clk) disable iff (rst)
        (rx_read_i && !done) |=> !rx_ready_o);

    assert_overrun_set_R3: assert property (@(posedge clk) disable iff (rst)
        (done && rx_ready_o && !rx_read_i) |=> overrun_o);

    assert_overrun_cause_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(overrun_o) |-> $past(done));

    assert_clear_cmd_R4: assert property (@(posedge clk) disable iff (rst)
        (ctl_wr_i && ctl_clr_status_i && !done) |=> (!overrun_o && !par_err_o));

    assert_overrun_sticky_R4: assert property (@(posedge clk) disable iff (rst)
        (overrun_o && !(ctl_wr_i && ctl_clr_status_i)) |=> overrun_o);

    assert_perr_with_char_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(par_err_o) |-> $past(done));

    assert_perr_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        (par_err_o && !(ctl_wr_i && ctl_clr_status_i)) |=> par_err_o);

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_no_parity_R9: assert property (@(posedge clk) disable iff (rst)
        (done && par_mode_i[2] && !par_err_o) |=> !par_err_o);
endmodule

bind dbg_uart_rx dbg_uart_rx_chk u_chk (
    .clk              (clk),
    .rst              (rst),
    .done             (frm_done),
    .par_mode_i       (par_mode_i),
    .rx_read_i        (rx_read_i),
    .ctl_wr_i         (ctl_wr_i),
    .ctl_clr_status_i (ctl_clr_status_i),
    .rx_ready_o       (rx_ready_o),
    .overrun_o        (overrun_o),
    .par_err_o        (par_err_o)
);

// File: tb/dbg_uart_rx_bench.sv
module dbg_uart_rx_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick16 = 1'b0;
    logic       ser_in = 1'b1;
    logic [2:0] par_mode = 3'b000;
    logic       rx_read = 1'b0;
    logic       ctl_wr = 1'b0;
    logic       ctl_clr = 1'b0;
    logic [7:0] rx_data;
    logic       rx_ready, overrun, par_err;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;
    logic [1:0] tdiv = 2'd0;

    always #2.5 clk = ~clk;   // 200 MHz

    // 16x tick every 4 clocks: one bit = 64 clocks
    always @(posedge clk) begin
        tdiv   <= tdiv + 2'd1;
        tick16 <= (tdiv == 2'd3);
    end

    dbg_uart_rx u_dbg_uart_rx (
        .clk              (clk),
        .rst              (rst),
        .tick16_i         (tick16),
        .ser_in_i         (ser_in),
        .par_mode_i       (par_mode),
        .rx_read_i        (rx_read),
        .ctl_wr_i         (ctl_wr),
        .ctl_clr_status_i (ctl_clr),
        .rx_data_o        (rx_data),
        .rx_ready_o       (rx_ready),
        .overrun_o        (overrun),
        .par_err_o        (par_err)
    );

    // {mode[2:0], data[7:0], invert parity bit, expected par_err}
    localparam logic [12:0] VEC [9] = '{
        {3'b000, 8'hA5, 1'b0, 1'b0},
        {3'b000, 8'h01, 1'b1, 1'b1},
        {3'b001, 8'h80, 1'b0, 1'b0},
        {3'b001, 8'h3C, 1'b1, 1'b1},
        {3'b010, 8'hFF, 1'b0, 1'b0},
        {3'b010, 8'h00, 1'b1, 1'b1},
        {3'b011, 8'h5A, 1'b0, 1'b0},
        {3'b011, 8'hC3, 1'b1, 1'b1},
        {3'b100, 8'h7E, 1'b1, 1'b0}
    };

    function automatic logic good_par(input logic [2:0] m, input logic [7:0] d);
        int ones = 0;
        for (int i = 0; i < 8; i++) ones += int'(d[i]);
        case (m[1:0])
            2'b00:   return (ones % 2) == 1;
            2'b01:   return (ones % 2) == 0;
            2'b10:   return 1'b0;
            default: return 1'b1;
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic hold_bit(input logic v);
        ser_in = v;
        repeat (64) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] d, input logic [2:0] m, input bit flip);
        hold_bit(1'b0);
        for (int i = 0; i < 8; i++) hold_bit(d[i]);
        if (!m[2]) hold_bit(good_par(m, d) ^ flip);
        hold_bit(1'b1);
        repeat (32) @(negedge clk);
    endtask

    task automatic do_read();
        @(negedge clk); rx_read = 1'b1;
        @(negedge clk); rx_read = 1'b0;
    endtask

    task automatic do_clear();
        @(negedge clk); ctl_wr = 1'b1; ctl_clr = 1'b1;
        @(negedge clk); ctl_wr = 1'b0; ctl_clr = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        check(rx_data == 8'h00, "R10 reset data", rx_data, 0);
        check({rx_ready, overrun, par_err} == 3'b000, "R10 reset flags",
              {rx_ready, overrun, par_err}, 0);
        repeat (40) @(negedge clk);

        // Table walk: R1, R2, R5, R8, R9
        for (int v = 0; v < 9; v++) begin
            logic [2:0] m;
            logic [7:0] d;
            m = VEC[v][12:10];
            d = VEC[v][9:2];
            par_mode = m;
            do_clear();
            send(d, m, VEC[v][1]);
            check(rx_data == d, "R8 data order", rx_data, d);
            check(rx_ready == 1'b1, "R1 ready", rx_ready, 1);
            check(par_err == VEC[v][0], m[2] ? "R9 no parity" : "R5 parity rule",
                  par_err, VEC[v][0]);
            check(overrun == 1'b0, "R3 no overrun", overrun, 0);
            do_read();
            check(rx_ready == 1'b0, "R2 read clears", rx_ready, 0);
            check(par_err == VEC[v][0], "R4 read keeps perr", par_err, VEC[v][0]);
        end

        // R3 overrun and overwrite
        par_mode = 3'b000;
        do_clear();
        send(8'h11, 3'b000, 1'b0);
        send(8'h22, 3'b000, 1'b0);
        check(overrun == 1'b1, "R3 overrun set", overrun, 1);
        check(rx_data == 8'h22, "R3 overwrite", rx_data, 8'h22);
        do_read();
        check(overrun == 1'b1, "R4 overrun kept after read", overrun, 1);
        send(8'h33, 3'b000, 1'b0);
        check(overrun == 1'b1, "R4 overrun kept over char", overrun, 1);
        do_clear();
        check(overrun == 1'b0, "R4 clear overrun", overrun, 0);
        check(rx_ready == 1'b1, "R4 clear keeps ready", rx_ready, 1);
        do_read();

        // R6 sticky parity error
        send(8'h0F, 3'b000, 1'b1);
        check(par_err == 1'b1, "R6 perr set", par_err, 1);
        do_read();
        send(8'hF0, 3'b000, 1'b0);
        check(par_err == 1'b1, "R6 perr sticky", par_err, 1);
        check(rx_data == 8'hF0, "R6 good char taken", rx_data, 8'hF0);
        do_read();
        do_clear();
        check(par_err == 1'b0, "R4 clear perr", par_err, 0);

        // R7 glitch rejection and recovery
        ser_in = 1'b0;
        repeat (12) @(negedge clk);
        ser_in = 1'b1;
        repeat (200) @(negedge clk);
        check({rx_ready, overrun, par_err} == 3'b000, "R7 glitch ignored",
              {rx_ready, overrun, par_err}, 0);
        send(8'h96, 3'b000, 1'b0);
        check(rx_data == 8'h96 && rx_ready, "R7 recovery", rx_data, 8'h96);

        // R10 reset with flags set
        send(8'h69, 3'b000, 1'b1);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        check({rx_ready, overrun, par_err} == 3'b000, "R10 reset clears flags",
              {rx_ready, overrun, par_err}, 0);
        check(rx_data == 8'h00, "R10 reset clears data", rx_data, 0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule